// File: doc/BRIEF.md
# SIMD Two-Operand Logic Unit

This execution unit takes a 64-bit register operand and a second operand, which is either another register or an 8-bit immediate widened inside each SIMD chunk. It applies one of eight bitwise boolean functions, chosen by a 3-bit function code, and returns the result one clock after the request. The same function code also selects single-bit operations: test, clear, change and set of one bit position. That position is applied at the same place in every chunk.

An optional combine step collapses each chunk of the result into a flag. Every bit of the chunk becomes one if the chunk reduces to true, and zero otherwise. The reduction is either an AND or an OR across the chunk. Chunks may be 8, 16, 32 or 64 bits wide. Register index 0 always reads as zero, so a NOT is written as NOR or XNOR against register 0.

A two-state controller tracks the output slot. In state ST_EMPTY, an accepted request takes transition ACCEPT to ST_FULL, and an idle cycle takes REST, which stays in ST_EMPTY. In state ST_FULL, a further request takes STREAM, which stays in ST_FULL, and an idle cycle takes RETIRE back to ST_EMPTY.

Top module: `simd_logic_unit`

## Requirements
- R1: With `bit_mode`=0, the result is F(B, A), where A is the first register and B is the second operand. The function codes are: 000 B&A, 001 B&~A, 010 B^A, 011 B|A, 100 ~(B|A), 101 ~(B^A), 110 B|~A, 111 ~(B&A). The register A is the operand that is inverted.
- R2: A register index of 0 reads as zero whatever its data input carries. NOR or XNOR with B taken from index 0 therefore gives ~A.
- R3: With `use_imm`=1, the 8-bit immediate fills the low 8 bits of every chunk. The upper bits of each chunk are zero when `imm_sext`=0 and copy immediate bit 7 when `imm_sext`=1.
- R4: With `bit_mode`=1, a one-hot mask M is applied to A. The codes are: 000 test (A&M), 001 clear (A&~M), 010 change (A^M), 011 set (A|M).
- R5: The bit position is the low six bits of the raw immediate (when `use_imm`=1) or of register B. It is taken modulo the chunk size, and M has that bit set in every chunk.
- R6: With `bit_mode`=1, codes 100 to 111 are reserved and give a zero result.
- R7: `combine_sel` 01 sets each chunk to all ones if every bit of the chunk is one. `combine_sel` 10 sets each chunk to all ones if any bit of the chunk is one. Otherwise the chunk becomes zero. Codes 00 and 11 leave the result unchanged.
- R8: `chunk_sel` encodes the chunk size as 00 = 8 bits, 01 = 16 bits, 10 = 32 bits and 11 = 64 bits.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. In that cycle `out_data` holds that request's result; in all other cycles `out_data` is zero. Back-to-back requests each produce a result.
- R10: During and after reset, `out_valid` and `out_data` are zero until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| func_code | input | 3 | Boolean or bit-operation function |
| bit_mode | input | 1 | Select single-bit operations |
| use_imm | input | 1 | Second operand is the immediate |
| imm_sext | input | 1 | Sign-extend the immediate within each chunk |
| combine_sel | input | 2 | Per-chunk reduction: 00 none, 01 AND, 10 OR, 11 none |
| chunk_sel | input | 2 | Chunk size: 8, 16, 32 or 64 bits |
| a_idx | input | 6 | Register index of A |
| a_data | input | 64 | Register value of A |
| b_idx | input | 6 | Register index of B |
| b_data | input | 64 | Register value of B |
| imm | input | 8 | Immediate operand |
| out_valid | output | 1 | Result present |
| out_data | output | 64 | Registered result |

## Verification
The bench targets the operand that is inverted in AND-NOT and OR-NOT. A design that inverts the wrong side returns ~B&A, which no longer equals ~A when B is all ones. It compares sign-extended and zero-extended immediates in 16-bit chunks, where a missing extension leaves 0x0080 in place of 0xFF80. It also uses bit positions above the chunk size, which a design without the modulo would place in only one chunk. Further targets are reserved bit codes that must give zero, register 0 carrying non-zero data, and combine flags that must fill whole chunks; a reduction taken over the wrong width gives partial flags. Random traffic across all modes and sizes is compared against a per-chunk reference model.

// File: rtl/simd_logic_pkg.sv
package simd_logic_pkg;
    typedef enum logic [1:0] {CH_8 = 2'b00, CH_16 = 2'b01, CH_32 = 2'b10, CH_64 = 2'b11} chunk_e;
    typedef enum logic [1:0] {CMB_NONE = 2'b00, CMB_AND = 2'b01, CMB_OR = 2'b10, CMB_RSVD = 2'b11} combine_e;
    typedef enum logic [0:0] {ST_EMPTY = 1'b0, ST_FULL = 1'b1} slot_state_e;

    function automatic int unsigned chunk_bits(input logic [1:0] sel);
        return 32'd8 << sel;
    endfunction
endpackage

// File: rtl/simd_operand_prep.sv
module simd_operand_prep
    import simd_logic_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8,
    parameter int RIDX_W = 6
) (
    input  logic [RIDX_W-1:0] a_idx,
    input  logic [DATA_W-1:0] a_data,
    input  logic [RIDX_W-1:0] b_idx,
    input  logic [DATA_W-1:0] b_data,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              imm_sext,
    input  logic [1:0]        chunk_sel,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] bit_mask
);
    localparam int POS_W     = $clog2(DATA_W);
    localparam int IMM_IDX_W = $clog2(IMM_W);

    logic [DATA_W-1:0] reg_b;
    logic [DATA_W-1:0] imm_wide;
    logic [POS_W-1:0]  size_m1;
    logic [POS_W-1:0]  sel_pos;
    logic [POS_W-1:0]  pos;

    assign opnd_a = (a_idx == '0) ? '0 : a_data;
    assign reg_b  = (b_idx == '0) ? '0 : b_data;

    always_comb begin
        size_m1 = POS_W'(chunk_bits(chunk_sel) - 1);
        sel_pos = (use_imm ? imm[POS_W-1:0] : reg_b[POS_W-1:0]) & size_m1;
        for (int i = 0; i < DATA_W; i++) begin
            pos = POS_W'(i) & size_m1;
            if (int'(pos) < IMM_W)
                imm_wide[i] = imm[pos[IMM_IDX_W-1:0]];
            else
                imm_wide[i] = imm_sext & imm[IMM_W-1];
            bit_mask[i] = (pos == sel_pos);
        end
    end

    assign opnd_b = use_imm ? imm_wide : reg_b;
endmodule

// File: rtl/simd_bool_core.sv
module simd_bool_core #(
    parameter int DATA_W = 64
) (
    input  logic [2:0]        func_code,
    input  logic              bit_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] bit_mask,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        result = '0;
        if (bit_mode) begin
            unique case (func_code)
                3'b000:  result = opnd_a & bit_mask;
                3'b001:  result = opnd_a & ~bit_mask;
                3'b010:  result = opnd_a ^ bit_mask;
                3'b011:  result = opnd_a | bit_mask;
                default: result = '0;
            endcase
        end else begin
            unique case (func_code)
                3'b000:  result = opnd_b & opnd_a;
                3'b001:  result = opnd_b & ~opnd_a;
                3'b010:  result = opnd_b ^ opnd_a;
                3'b011:  result = opnd_b | opnd_a;
                3'b100:  result = ~(opnd_b | opnd_a);
                3'b101:  result = ~(opnd_b ^ opnd_a);
                3'b110:  result = opnd_b | ~opnd_a;
                default: result = ~(opnd_b & opnd_a);
            endcase
        end
    end
endmodule

// File: rtl/simd_chunk_reduce.sv
module simd_chunk_reduce
    import simd_logic_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] result_in,
    input  logic [1:0]        chunk_sel,
    input  logic [1:0]        combine_sel,
    output logic [DATA_W-1:0] result_out
);
    localparam int N8  = DATA_W / 8;
    localparam int N16 = N8 / 2;
    localparam int N32 = N8 / 4;
    localparam int N64 = N8 / 8;

    logic [N8-1:0]  all8,  any8;
    logic [N16-1:0] all16, any16;
    logic [N32-1:0] all32, any32;
    logic [N64-1:0] all64, any64;

    for (genvar g = 0; g < N8; g++) begin : g_byte
        assign all8[g] = &result_in[g*8 +: 8];
        assign any8[g] = |result_in[g*8 +: 8];
    end
    for (genvar g = 0; g < N16; g++) begin : g_half
        assign all16[g] = all8[2*g] & all8[2*g+1];
        assign any16[g] = any8[2*g] | any8[2*g+1];
    end
    for (genvar g = 0; g < N32; g++) begin : g_word
        assign all32[g] = all16[2*g] & all16[2*g+1];
        assign any32[g] = any16[2*g] | any16[2*g+1];
    end
    for (genvar g = 0; g < N64; g++) begin : g_dword
        assign all64[g] = all32[2*g] & all32[2*g+1];
        assign any64[g] = any32[2*g] | any32[2*g+1];
    end

    logic flag_all, flag_any;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            unique case (chunk_e'(chunk_sel))
                CH_8:    begin flag_all = all8[i/8];   flag_any = any8[i/8];   end
                CH_16:   begin flag_all = all16[i/16]; flag_any = any16[i/16]; end
                CH_32:   begin flag_all = all32[i/32]; flag_any = any32[i/32]; end
                default: begin flag_all = all64[i/64]; flag_any = any64[i/64]; end
            endcase
            unique case (combine_e'(combine_sel))
                CMB_AND: result_out[i] = flag_all;
                CMB_OR:  result_out[i] = flag_any;
                default: result_out[i] = result_in[i];
            endcase
        end
    end
endmodule

// File: rtl/simd_logic_unit.sv
module simd_logic_unit
    import simd_logic_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8,
    parameter int RIDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        func_code,
    input  logic              bit_mode,
    input  logic              use_imm,
    input  logic              imm_sext,
    input  logic [1:0]        combine_sel,
    input  logic [1:0]        chunk_sel,
    input  logic [RIDX_W-1:0] a_idx,
    input  logic [DATA_W-1:0] a_data,
    input  logic [RIDX_W-1:0] b_idx,
    input  logic [DATA_W-1:0] b_data,
    input  logic [IMM_W-1:0]  imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] opnd_a, opnd_b, bit_mask, raw_res, final_res;
    slot_state_e state, state_nxt;

    simd_operand_prep #(.DATA_W(DATA_W), .IMM_W(IMM_W), .RIDX_W(RIDX_W)) u_prep (
        .a_idx(a_idx), .a_data(a_data), .b_idx(b_idx), .b_data(b_data),
        .imm(imm), .use_imm(use_imm), .imm_sext(imm_sext), .chunk_sel(chunk_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .bit_mask(bit_mask)
    );

    simd_bool_core #(.DATA_W(DATA_W)) u_core (
        .func_code(func_code), .bit_mode(bit_mode), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .bit_mask(bit_mask), .result(raw_res)
    );

    simd_chunk_reduce #(.DATA_W(DATA_W)) u_reduce (
        .result_in(raw_res), .chunk_sel(chunk_sel),
        .combine_sel(combine_sel), .result_out(final_res)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: state_nxt = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_nxt = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        out_data <= '0;
        else if (in_valid) out_data <= final_res;
        else               out_data <= '0;
    end

    assign out_valid = (state == ST_FULL);
endmodule

// File: rtl/simd_logic_unit_chk.sv
module simd_logic_unit_chk #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8,
    parameter int RIDX_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        func_code,
    input logic              bit_mode,
    input logic              use_imm,
    input logic              imm_sext,
    input logic [1:0]        combine_sel,
    input logic [1:0]        chunk_sel,
    input logic [RIDX_W-1:0] a_idx,
    input logic [DATA_W-1:0] a_data,
    input logic [RIDX_W-1:0] b_idx,
    input logic [DATA_W-1:0] b_data,
    input logic [IMM_W-1:0]  imm,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_data == '0);
    // R6
    rsvd_bitop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bit_mode && func_code[2]) |=> out_data == '0);
    // R7
    combine_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chunk_sel == 2'b11 && (combine_sel == 2'b01 || combine_sel == 2'b10))
        |=> (out_data == '0 || out_data == '1));
    // R2
    zero_reg_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bit_mode && func_code == 3'b000 && a_idx == '0 && combine_sel != 2'b01)
        |=> out_data == '0);
endmodule

bind simd_logic_unit simd_logic_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .RIDX_W(RIDX_W)) u_chk (.*);

// File: tb/simd_logic_unit_test.sv
module simd_logic_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  func_code = '0;
    logic        bit_mode = 1'b0, use_imm = 1'b0, imm_sext = 1'b0;
    logic [1:0]  combine_sel = '0, chunk_sel = '0;
    logic [5:0]  a_idx = '0, b_idx = '0;
    logic [63:0] a_data = '0, b_data = '0;
    logic [7:0]  imm = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    simd_logic_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .func_code(func_code),
        .bit_mode(bit_mode), .use_imm(use_imm), .imm_sext(imm_sext),
        .combine_sel(combine_sel), .chunk_sel(chunk_sel), .a_idx(a_idx),
        .a_data(a_data), .b_idx(b_idx), .b_data(b_data), .imm(imm),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [63:0] ref_model(
        input logic [2:0] f, input logic bm, input logic ui, input logic sx,
        input logic [1:0] cm, input logic [1:0] ch, input logic [5:0] ai,
        input logic [63:0] ad, input logic [5:0] bi, input logic [63:0] bd,
        input logic [7:0] im);
        int cs, idx;
        logic [63:0] a, bv, cmask, ext, ca, cb, mk, r, acc;
        cs = 8 << ch;
        a = (ai == 0) ? 64'd0 : ad;
        bv = (bi == 0) ? 64'd0 : bd;
        cmask = (cs == 64) ? {64{1'b1}} : ((64'd1 << cs) - 64'd1);
        ext = (sx ? {{56{im[7]}}, im} : {56'd0, im}) & cmask;
        idx = int'(ui ? im[5:0] : bv[5:0]) % cs;
        mk = 64'd1 << idx;
        acc = '0;
        for (int c = 0; c < 64 / cs; c++) begin
            ca = (a >> (c * cs)) & cmask;
            cb = ui ? ext : ((bv >> (c * cs)) & cmask);
            if (bm) begin
                case (f)
                    3'd0: r = ca & mk;
                    3'd1: r = ca & ~mk;
                    3'd2: r = ca ^ mk;
                    3'd3: r = ca | mk;
                    default: r = '0;
                endcase
            end else begin
                case (f)
                    3'd0: r = cb & ca;
                    3'd1: r = cb & ~ca;
                    3'd2: r = cb ^ ca;
                    3'd3: r = cb | ca;
                    3'd4: r = ~(cb | ca);
                    3'd5: r = ~(cb ^ ca);
                    3'd6: r = cb | ~ca;
                    default: r = ~(cb & ca);
                endcase
            end
            r &= cmask;
            if (cm == 2'b01) r = (r == cmask) ? cmask : 64'd0;
            else if (cm == 2'b10) r = (r != 0) ? cmask : 64'd0;
            acc |= r << (c * cs);
        end
        return acc;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // drive one request at a negedge, check the result at the next negedge
    task automatic run_op(input string req, input logic [2:0] f, input logic bm,
        input logic ui, input logic sx, input logic [1:0] cm, input logic [1:0] ch,
        input logic [5:0] ai, input logic [63:0] ad, input logic [5:0] bi,
        input logic [63:0] bd, input logic [7:0] im);
        logic [63:0] exp;
        exp = ref_model(f, bm, ui, sx, cm, ch, ai, ad, bi, bd, im);
        in_valid = 1'b1; func_code = f; bit_mode = bm; use_imm = ui; imm_sext = sx;
        combine_sel = cm; chunk_sel = ch; a_idx = ai; a_data = ad; b_idx = bi;
        b_data = bd; imm = im;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid (R9)"}, {63'd0, out_valid}, 64'd1);
        check(req, out_data, exp);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250101));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset valid", {63'd0, out_valid}, 64'd0);
        check("R10 reset data", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", {63'd0, out_valid}, 64'd0);

        // R1: AND-NOT inverts register A
        run_op("R1 andn", 3'b001, 0, 0, 0, 2'b00, 2'b11, 6'd3, 64'hFF00_FF00_1234_5678,
               6'd4, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
        check("R1 andn value", out_data, 64'h00FF_00FF_EDCB_A987);
        // R1: OR-NOT with zero immediate and A = 0 gives all ones
        run_op("R1 orn imm", 3'b110, 0, 1, 0, 2'b00, 2'b00, 6'd5, 64'd0, 6'd0, 64'd0, 8'h00);
        // R2: NOT through NOR and XNOR with register 0
        run_op("R2 nor r0", 3'b100, 0, 0, 0, 2'b00, 2'b11, 6'd7, 64'h0F0F_0000_FFFF_1234,
               6'd0, 64'hDEAD_BEEF_0000_0001, 8'h00);
        check("R2 not value", out_data, 64'hF0F0_FFFF_0000_EDCB);
        run_op("R2 xnor r0", 3'b101, 0, 0, 0, 2'b00, 2'b10, 6'd7, 64'h1, 6'd0, 64'h55, 8'h00);
        // R2: index 0 on A masks its data
        run_op("R2 a r0", 3'b011, 0, 0, 0, 2'b00, 2'b11, 6'd0, 64'hFFFF_0000_0000_0000,
               6'd9, 64'h0000_0000_0000_00A5, 8'h00);
        // R3: zero- versus sign-extended immediate in 16-bit chunks
        run_op("R3 zext", 3'b011, 0, 1, 0, 2'b00, 2'b01, 6'd0, 64'd0, 6'd0, 64'd0, 8'h80);
        check("R3 zext value", out_data, 64'h0080_0080_0080_0080);
        run_op("R3 sext", 3'b011, 0, 1, 1, 2'b00, 2'b01, 6'd0, 64'd0, 6'd0, 64'd0, 8'h80);
        check("R3 sext value", out_data, 64'hFF80_FF80_FF80_FF80);
        // R4 R5: bit set at index 13 in bytes lands on bit 5 of each byte
        run_op("R4 R5 bset", 3'b011, 1, 1, 0, 2'b00, 2'b00, 6'd1, 64'd0, 6'd0, 64'd0, 8'd13);
        check("R5 bset value", out_data, 64'h2020_2020_2020_2020);
        // R4: bit clear from register index 40 in 32-bit chunks (bit 8)
        run_op("R4 bclr", 3'b001, 1, 0, 0, 2'b00, 2'b10, 6'd2, 64'hFFFF_FFFF_FFFF_FFFF,
               6'd3, 64'd40, 8'h00);
        check("R4 bclr value", out_data, 64'hFFFF_FEFF_FFFF_FEFF);
        // R6: reserved bit operations
        for (int k = 4; k < 8; k++)
            run_op("R6 reserved", 3'(k), 1, 1, 0, 2'b00, 2'b00, 6'd1,
                   64'hFFFF_FFFF_FFFF_FFFF, 6'd0, 64'd0, 8'd3);
        // R7 R8: AND combine in 32-bit chunks
        run_op("R7 R8 and-combine", 3'b011, 0, 0, 0, 2'b01, 2'b10, 6'd1,
               64'h0000_0001_FFFF_FFFF, 6'd2, 64'd0, 8'h00);
        check("R7 and-combine value", out_data, 64'h0000_0000_FFFF_FFFF);
        run_op("R7 or-combine", 3'b011, 0, 0, 0, 2'b10, 2'b00, 6'd1,
               64'h0000_0100_0000_0000, 6'd2, 64'd0, 8'h00);
        check("R7 or-combine value", out_data, 64'h0000_FF00_0000_0000);
        run_op("R7 combine code 11", 3'b011, 0, 0, 0, 2'b11, 2'b00, 6'd1,
               64'h0000_0100_0000_0000, 6'd2, 64'd0, 8'h00);
        // R9: idle cycle after a request
        @(negedge clk);
        check("R9 drop valid", {63'd0, out_valid}, 64'd0);
        check("R9 idle data", out_data, 64'd0);

        // R1 R3 R4 R5 R7 R8 R9: random back-to-back traffic
        for (int n = 0; n < 600; n++) begin
            run_op("R1 R4 R7 random", 3'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 2'($urandom), 2'($urandom), 6'($urandom % 4),
                   {$urandom, $urandom}, 6'($urandom % 4), {$urandom, $urandom},
                   8'($urandom));
            if (($urandom % 5) == 0) @(negedge clk);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule